// File: doc/BRIEF.md
# Cipher Job Control Sequencer

This block is the control/status register and job sequencer that sits in front of a block-cipher datapath. Software writes a 32-bit control word that picks the chaining mode and direction, the authentication-tag length and where the tag comes from, and whether completion raises an interrupt. A separate length word supplies the job size in 16-byte blocks. Setting the start bit launches the job. The sequencer then offers one block request to the datapath for each input block that is available. It counts down on every accepted request, and when the count reaches zero it drops busy, latches the tag-check result and pulses done.

The datapath request is a valid/ready stream. `req_valid` is high only while a job is running and the surrounding logic reports an input block (`blk_avail`). A request is accepted in any cycle where `req_valid` and `req_ready` are both high. The datapath may hold `req_ready` low for any number of cycles, and the request stays offered with unchanged mode outputs. `blk_avail` may also drop at any time, which withdraws the offer. Nothing else waits on the requests. Control and status pins are plain levels or pulses.

Top module: `cipher_job_ctrl`

## Requirements
- R1: After reset, `ctl_rdata`, `blk_left`, `done`, `irq` and `req_valid` are all 0.
- R2: A write to the length word while idle loads bits 31:16 into the block counter (`blk_left`); bits 15:0 of that write are ignored.
- R3: Control bits 29:27 hold the mode code, which reads back there and drives `req_chain`/`req_encrypt`. The codes are: 0 CCM decrypt, 1 CCM encrypt, 2 and 3 CTR, 4 CBC decrypt, 5 CBC encrypt, 6 ECB decrypt, 7 ECB encrypt. `req_chain` is 0 CCM, 1 CTR, 2 CBC, 3 ECB, and `req_encrypt` is 1 for both CTR codes.
- R4: Control bits 18:16 hold the tag-size code f, and `mac_len` = 2*f+2 bytes. Bit 20 is the tag source (0 = from the data stream, 1 = from the dedicated tag register) and drives `mac_from_reg`. Both fields read back in place.
- R5: A control write with bit 31 = 1 while idle and with a non-zero counter makes bit 31 read 1 from the next cycle. While it is 1, `req_valid` equals `blk_avail`.
- R6: Each cycle with `req_valid` and `req_ready` both high decrements `blk_left` by one at that edge. No other cycle of a running job changes it.
- R7: In the cycle after the final accepted request, bit 31 reads 0 and `done` is 1 for exactly one cycle. Bit 21 then holds the value of `mac_ok_in` sampled at that edge (1 = verified, 0 = invalid).
- R8: A start with a zero counter never raises bit 31 or `req_valid`. It gives the `done` pulse and updates bit 21 in the next cycle.
- R9: `irq` is sticky. It is set together with `done` if bit 30 (taking the value in a same-cycle control write) is 1. Any control write clears it, but setting wins over clearing in the same cycle.
- R10: While bit 31 is 1, control writes leave the mode bits unchanged and length writes leave `blk_left` unchanged. Bit 30 still takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback with busy and tag status |
| len_wr | input | 1 | Length word write strobe |
| len_wdata | input | 32 | Length word; bits 31:16 are the block count |
| blk_avail | input | 1 | An input block is ready to be processed |
| mac_ok_in | input | 1 | Tag-check result from the datapath, sampled at completion |
| req_valid | output | 1 | Block request offered to the datapath |
| req_ready | input | 1 | Datapath accepts the block request |
| req_chain | output | 2 | Chaining kind for the datapath |
| req_encrypt | output | 1 | Direction for the datapath (1 = encrypt) |
| mac_len | output | 5 | Tag length in bytes |
| mac_from_reg | output | 1 | Tag is taken from the dedicated register |
| blk_left | output | 16 | Blocks still to be requested |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The decode is swept over all 64 pairs of mode code and tag-size code, with the tag source alternating, so that every chaining kind, direction and tag length is checked against arithmetic. Jobs of 0 to 6 blocks run under five stall patterns: free flow, a ready that toggles, gaps in block availability, and two mixed patterns. These tell apart counting on accepted requests from counting on offered requests, and show that the done pulse lands one cycle after the last accept and never earlier. Zero-length jobs, writes made mid-job, and alternating interrupt-enable and tag-result values separate the immediate-completion path, the mode and length lock, and the sticky interrupt with its set-wins rule.

// File: rtl/cje_pkg.sv
package cje_pkg;
  localparam int CTL_W      = 32;
  localparam int START_BIT  = 31;
  localparam int IE_BIT     = 30;
  localparam int MODE_LSB   = 27;
  localparam int MODE_W     = 3;
  localparam int MACOK_BIT  = 21;
  localparam int MACSRC_BIT = 20;
  localparam int MACSZ_LSB  = 16;
  localparam int MACSZ_W    = 3;
  localparam int LEN_LSB    = 16;
  localparam int CNT_W      = 16;
  localparam int MACLEN_W   = MACSZ_W + 2;

  typedef enum logic [1:0] {
    CH_CCM = 2'd0,
    CH_CTR = 2'd1,
    CH_CBC = 2'd2,
    CH_ECB = 2'd3
  } chain_e;

  typedef struct packed {
    chain_e chain;
    logic   encrypt;
  } op_t;

  function automatic op_t decode_mode(input logic [MODE_W-1:0] code);
    op_t o;
    case (code[2:1])
      2'd0:    begin o.chain = CH_CCM; o.encrypt = code[0]; end
      2'd1:    begin o.chain = CH_CTR; o.encrypt = 1'b1;    end
      2'd2:    begin o.chain = CH_CBC; o.encrypt = code[0]; end
      default: begin o.chain = CH_ECB; o.encrypt = code[0]; end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/cje_ctrl_reg.sv
module cje_ctrl_reg
  import cje_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               w_start,
  input  logic               w_ie,
  input  logic [MODE_W-1:0]  w_mode,
  input  logic               w_src,
  input  logic [MACSZ_W-1:0] w_sz,
  input  logic               busy,
  output logic               start_req,
  output logic               ie_q,
  output logic               ie_next,
  output logic [MODE_W-1:0]  mode_q,
  output logic               src_q,
  output logic [MACSZ_W-1:0] sz_q
);
  assign start_req = wr && w_start && !busy;
  assign ie_next   = wr ? w_ie : ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mode_q <= '0;
      src_q  <= 1'b0;
      sz_q   <= '0;
    end else if (wr) begin
      ie_q  <= w_ie;
      src_q <= w_src;
      sz_q  <= w_sz;
      if (!busy) mode_q <= w_mode;
    end
  end
endmodule

// File: rtl/cje_blk_seq.sv
module cje_blk_seq
  import cje_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             len_wr,
  input  logic [CNT_W-1:0] len_cnt,
  input  logic             blk_avail,
  input  logic             req_ready,
  input  logic             mac_ok_in,
  output logic             req_valid,
  output logic             busy,
  output logic             done,
  output logic             finish,
  output logic             mac_ok,
  output logic [CNT_W-1:0] count
);
  logic fire, last, empty_start;

  assign req_valid   = busy && blk_avail;
  assign fire        = req_valid && req_ready;
  assign last        = fire && (count == CNT_W'(1));
  assign empty_start = start_req && (count == '0);
  assign finish      = empty_start || last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      mac_ok <= 1'b0;
    end else begin
      done <= finish;
      if (finish) mac_ok <= mac_ok_in;
      if (start_req && !empty_start) busy <= 1'b1;
      else if (last) busy <= 1'b0;
      if (fire) count <= count - CNT_W'(1);
      else if (len_wr && !busy) count <= len_cnt;
    end
  end
endmodule

// File: rtl/cje_irq_flag.sv
module cje_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end
endmodule

// File: rtl/cipher_job_ctrl.sv
module cipher_job_ctrl
  import cje_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [CTL_W-1:0]    ctl_wdata,
  output logic [CTL_W-1:0]    ctl_rdata,
  input  logic                len_wr,
  input  logic [CTL_W-1:0]    len_wdata,
  input  logic                blk_avail,
  input  logic                mac_ok_in,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [1:0]          req_chain,
  output logic                req_encrypt,
  output logic [MACLEN_W-1:0] mac_len,
  output logic                mac_from_reg,
  output logic [CNT_W-1:0]    blk_left,
  output logic                done,
  output logic                irq
);
  logic               start_req, ie_q, ie_next, src_q, busy, finish, mac_ok;
  logic [MODE_W-1:0]  mode_q;
  logic [MACSZ_W-1:0] sz_q;
  op_t                op;
  logic               unused_bits;

  assign unused_bits = ^{ctl_wdata[26:21], ctl_wdata[19], ctl_wdata[15:0],
                         len_wdata[LEN_LSB-1:0]};

  cje_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr),
    .w_start(ctl_wdata[START_BIT]), .w_ie(ctl_wdata[IE_BIT]),
    .w_mode(ctl_wdata[MODE_LSB +: MODE_W]), .w_src(ctl_wdata[MACSRC_BIT]),
    .w_sz(ctl_wdata[MACSZ_LSB +: MACSZ_W]), .busy(busy),
    .start_req(start_req), .ie_q(ie_q), .ie_next(ie_next),
    .mode_q(mode_q), .src_q(src_q), .sz_q(sz_q)
  );

  cje_blk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .len_wr(len_wr),
    .len_cnt(len_wdata[LEN_LSB +: CNT_W]), .blk_avail(blk_avail),
    .req_ready(req_ready), .mac_ok_in(mac_ok_in), .req_valid(req_valid),
    .busy(busy), .done(done), .finish(finish), .mac_ok(mac_ok),
    .count(blk_left)
  );

  cje_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(finish && ie_next),
    .clr_evt(ctl_wr), .flag(irq)
  );

  assign op           = decode_mode(mode_q);
  assign req_chain    = op.chain;
  assign req_encrypt  = op.encrypt;
  assign mac_len      = {1'b0, sz_q, 1'b0} + MACLEN_W'(2);
  assign mac_from_reg = src_q;

  always_comb begin
    ctl_rdata                          = '0;
    ctl_rdata[START_BIT]               = busy;
    ctl_rdata[IE_BIT]                  = ie_q;
    ctl_rdata[MODE_LSB +: MODE_W]      = mode_q;
    ctl_rdata[MACOK_BIT]               = mac_ok;
    ctl_rdata[MACSRC_BIT]              = src_q;
    ctl_rdata[MACSZ_LSB +: MACSZ_W]    = sz_q;
  end
endmodule

// File: rtl/cje_chk.sv
module cje_chk
  import cje_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [CTL_W-1:0]    ctl_rdata,
  input logic                req_valid,
  input logic                req_ready,
  input logic                blk_avail,
  input logic [CNT_W-1:0]    blk_left,
  input logic                done,
  input logic                irq,
  input logic [MACLEN_W-1:0] mac_len
);
  // R5: a request is offered only while running and a block is available
  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (ctl_rdata[START_BIT] && blk_avail));

  // R6: an accepted request takes one block off the counter
  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (blk_left == $past(blk_left) - CNT_W'(1)));

  // R7: the done pulse comes with busy low
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctl_rdata[START_BIT]);

  // R7: busy falls only together with done
  p_fall_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_rdata[START_BIT]) |-> done);

  // R9: the interrupt rises only at completion
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);

  // R10: the mode is frozen across running cycles
  p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[START_BIT] && $past(ctl_rdata[START_BIT]))
      |-> $stable(ctl_rdata[MODE_LSB +: MODE_W]));

  // R4: tag length is even and between 2 and 16 bytes
  p_maclen_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_len[0] && (mac_len >= MACLEN_W'(2)) && (mac_len <= MACLEN_W'(16)));
endmodule

bind cipher_job_ctrl cje_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .req_valid(req_valid),
  .req_ready(req_ready), .blk_avail(blk_avail), .blk_left(blk_left),
  .done(done), .irq(irq), .mac_len(mac_len)
);

// File: tb/tb_cipher_job_ctrl.sv
`timescale 1ns/1ps
module tb_cipher_job_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        len_wr = 1'b0;
  logic [31:0] len_wdata = '0;
  logic        blk_avail = 1'b0;
  logic        mac_ok_in = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [1:0]  req_chain;
  logic        req_encrypt;
  logic [4:0]  mac_len;
  logic        mac_from_reg;
  logic [15:0] blk_left;
  logic        done;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  cipher_job_ctrl dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic logic [31:0] mk_ctl(input bit st, input bit ie, input int mode,
                                         input bit src, input int sz);
    logic [31:0] w;
    w = '0;
    w[31] = st;
    w[30] = ie;
    w[29:27] = mode[2:0];
    w[20] = src;
    w[18:16] = sz[2:0];
    return w;
  endfunction

  task automatic ctl_write(input logic [31:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic len_write(input logic [31:0] d);
    len_wr = 1'b1; len_wdata = d;
    @(negedge clk);
    len_wr = 1'b0;
  endtask

  function automatic bit pat_avail(input int p, input int c);
    case (p)
      0: return 1'b1;
      1: return 1'b1;
      2: return (c % 3) != 0;
      3: return (c % 2) == 0;
      default: return ((c * 5 + 1) % 7) < 4;
    endcase
  endfunction

  function automatic bit pat_ready(input int p, input int c);
    case (p)
      0: return 1'b1;
      1: return (c % 2) == 1;
      2: return 1'b1;
      3: return (c % 3) != 1;
      default: return (c % 4) != 3;
    endcase
  endfunction

  task automatic run_job(input int n, input int pat, input bit mok, input bit ie);
    int acc;
    int cyc;
    bit a, r;
    len_write({n[15:0], 16'hBEEF});
    chk(blk_left == n[15:0], "R2 length load", blk_left, n);
    mac_ok_in = mok;
    ctl_write(mk_ctl(1'b1, ie, pat % 8, 1'b0, 0));
    if (n == 0) begin
      chk(done == 1'b1, "R8 zero job done", done, 1);
      chk(ctl_rdata[31] == 1'b0, "R8 zero job never busy", ctl_rdata[31], 0);
      chk(ctl_rdata[21] == mok, "R8 tag status", ctl_rdata[21], mok);
      chk(irq == ie, "R9 irq at zero job", irq, ie);
      blk_avail = 1'b1; req_ready = 1'b1;
      #1;
      chk(req_valid == 1'b0, "R8 no request", req_valid, 0);
    end else begin
      chk(ctl_rdata[31] == 1'b1, "R5 busy after start", ctl_rdata[31], 1);
      acc = 0;
      cyc = 0;
      while (acc < n && cyc < 200) begin
        a = pat_avail(pat, cyc);
        r = pat_ready(pat, cyc);
        blk_avail = a; req_ready = r;
        #1;
        chk(req_valid == a, "R5 valid follows avail", req_valid, a);
        @(negedge clk);
        if (a && r) acc++;
        chk(blk_left == 16'(n - acc), "R6 count", blk_left, n - acc);
        if (acc < n) begin
          chk(ctl_rdata[31] == 1'b1, "R7 busy held", ctl_rdata[31], 1);
          chk(done == 1'b0, "R7 no early done", done, 0);
        end
        cyc++;
      end
      chk(done == 1'b1, "R7 done after last", done, 1);
      chk(ctl_rdata[31] == 1'b0, "R7 busy cleared", ctl_rdata[31], 0);
      chk(ctl_rdata[21] == mok, "R7 tag status", ctl_rdata[21], mok);
      chk(irq == ie, "R9 irq at done", irq, ie);
      blk_avail = 1'b1; req_ready = 1'b1;
      #1;
      chk(req_valid == 1'b0, "R5 no request when idle", req_valid, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(irq == ie, "R9 irq sticky", irq, ie);
    blk_avail = 1'b0; req_ready = 1'b0;
    ctl_write(32'h0);
    chk(irq == 1'b0, "R9 irq cleared by write", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_rdata == 32'h0, "R1 ctl_rdata", ctl_rdata, 0);
    chk(blk_left == 16'h0, "R1 blk_left", blk_left, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);

    // R3 and R4: full sweep of mode and tag-size codes
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 8; s++) begin
        bit src;
        int ech, een;
        src = bit'((m + s) % 2);
        ctl_write(mk_ctl(1'b0, 1'b0, m, src, s));
        ech = m / 2;
        een = (m == 2 || m == 3) ? 1 : (m % 2);
        chk(req_chain == 2'(ech), "R3 chain", req_chain, ech);
        chk(req_encrypt == een[0], "R3 direction", req_encrypt, een);
        chk(ctl_rdata[29:27] == 3'(m), "R3 mode readback", ctl_rdata[29:27], m);
        chk(mac_len == 5'(2 * s + 2), "R4 tag length", mac_len, 2 * s + 2);
        chk(mac_from_reg == src, "R4 tag source", mac_from_reg, src);
        chk(ctl_rdata[18:16] == 3'(s) && ctl_rdata[20] == src, "R4 readback",
            ctl_rdata[20:16], {src, 1'b0, s[2:0]});
        chk(ctl_rdata[31] == 1'b0, "R5 idle without start", ctl_rdata[31], 0);
      end
    end

    // R5..R9 jobs over lengths and stall patterns
    for (int n = 0; n < 7; n++)
      for (int p = 0; p < 5; p++)
        run_job(n, p, bit'((n * 3 + p) % 2), bit'((n + p) % 2));

    // R10: writes during a running job
    len_write({16'd5, 16'h0});
    ctl_write(mk_ctl(1'b1, 1'b0, 5, 1'b0, 0));
    chk(ctl_rdata[31] == 1'b1, "R10 running", ctl_rdata[31], 1);
    ctl_write(mk_ctl(1'b0, 1'b1, 2, 1'b1, 7));
    chk(ctl_rdata[29:27] == 3'd5, "R10 mode locked", ctl_rdata[29:27], 5);
    chk(req_chain == 2'd2 && req_encrypt, "R10 decode kept", {req_chain, req_encrypt}, 5);
    chk(ctl_rdata[30] == 1'b1, "R10 enable written", ctl_rdata[30], 1);
    chk(ctl_rdata[31] == 1'b1, "R10 still running", ctl_rdata[31], 1);
    len_write({16'd9, 16'h0});
    chk(blk_left == 16'd5, "R10 length locked", blk_left, 5);
    blk_avail = 1'b1; req_ready = 1'b1;
    mac_ok_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R7 done after five", done, 1);
    chk(irq == 1'b1, "R9 irq from mid-job enable", irq, 1);
    chk(blk_left == 16'd0, "R6 drained", blk_left, 0);
    blk_avail = 1'b0; req_ready = 1'b0;
    @(negedge clk);
    // R9: a start write on an empty counter sets irq despite being a write
    ctl_write(mk_ctl(1'b1, 1'b1, 0, 1'b0, 0));
    chk(irq == 1'b1, "R9 set wins over clear", irq, 1);
    @(negedge clk);
    finish_run();
  end
endmodule